// File: doc/BRIEF.md
# Four-Slot Wide-Word Execution Core

This core executes one 100-bit instruction word per clock. Each word carries four independent slots: two arithmetic slots, one memory slot and one control slot. All four slots read a shared bank of 64 general registers, and the results they produce are committed together at the clock edge that ends the cycle. Within a word no slot can see another slot's result. Every read in a word returns the value the register held before that word began.

Instruction fetch is outside the core. The core receives a word together with a valid flag. Memory traffic goes out through a single-cycle request port, and the load data must come back in the same cycle. Branch resolution is also handled by the core, which reports whether to take the branch and where the target is. A return address for calls comes from the fetch side and is written into the named register. There is no divider, so the divide encoding behaves as a no-op and every word completes in one cycle.

Top module: `vliw_core`

## Requirements
- R1: After reset all 64 registers read as zero.
- R2: Word bit fields, MSB first, are as follows. First arithmetic slot: src1 [99:94], src2 [93:88], op [87:84], dest [83:78]. Second arithmetic slot: src1 [77:72], src2 [71:66], op [65:62], dest [61:56]. Memory slot: op [55:52], reg [51:46], index [45:40], disp [39:28]. Control slot: op [27:24], reg [23:18], index [17:12], disp [11:0].
- R3: Arithmetic op codes write dest with src1 op src2: 1 add, 2 subtract (src1 minus src2), 3 multiply (low XLEN bits), 5 and, 6 or, 7 xor.
- R4: Arithmetic op 0, op 4 (divide, not provided) and ops 8 to 15 write nothing. Memory ops 4 to 15 and control ops 5 to 15 raise no request and write nothing.
- R5: The memory address is index register plus the 12-bit displacement sign-extended. Memory op 1 (load) asserts mem_valid with mem_we low and writes reg with mem_rdata. Op 2 (store) asserts mem_valid and mem_we and drives mem_wdata with reg. Op 3 (load immediate) writes reg with the 18-bit value {index field, disp field} zero-extended and raises no request.
- R6: Control op 1 (jump) and op 2 (call) always take. Op 3 takes when reg equals zero. Op 4 takes when reg is greater than zero as a signed value. br_target is index register plus the sign-extended displacement. A call writes br_link into reg.
- R7: Every slot reads register values as they stood before the word. A register written by one slot is seen by other slots only from the next word onward.
- R8: When several slots write the same register in one word, the memory slot (load or load immediate) wins over a call, a call wins over the second arithmetic slot, and the second arithmetic slot wins over the first.
- R9: With instr_valid low, mem_valid and br_take stay low and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 100 | Instruction word |
| mem_valid | output | 1 | Memory request this cycle |
| mem_we | output | 1 | Request is a store |
| mem_addr | output | XLEN | Effective memory address |
| mem_wdata | output | XLEN | Store data |
| mem_rdata | input | XLEN | Load data, returned in the same cycle |
| br_take | output | 1 | Branch taken |
| br_target | output | XLEN | Branch target address |
| br_link | input | XLEN | Return address written by a call |

## Verification
The hardest case to reach from the ports is a single word in which several slots write the same register while other slots read it. The bench stacks a load, a call and both arithmetic slots onto one destination. It then removes the winning writer one step at a time and reads the register back after each step. A separate word both rewrites a register and reads it in a second arithmetic slot and in a store. The store's mem_wdata is sampled in that same cycle, which shows that all reads see the value from before the word.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
  localparam int RW   = 6;
  localparam int OW   = 4;
  localparam int DW   = 12;
  localparam int NREG = 2 ** RW;
  localparam int IW   = 10 * RW + 4 * OW + 2 * DW;
  localparam int NRD  = 8;
  localparam int NWR  = 4;

  typedef struct packed {
    logic [RW-1:0] s1;
    logic [RW-1:0] s2;
    logic [OW-1:0] op;
    logic [RW-1:0] dst;
  } alu_slot_t;

  typedef struct packed {
    logic [OW-1:0] op;
    logic [RW-1:0] r;
    logic [RW-1:0] x;
    logic [DW-1:0] disp;
  } ref_slot_t;

  typedef struct packed {
    alu_slot_t a;
    alu_slot_t b;
    ref_slot_t m;
    ref_slot_t c;
  } word_t;

  typedef enum logic [OW-1:0] {
    ALU_NOP = 4'd0, ALU_ADD = 4'd1, ALU_SUB = 4'd2, ALU_MUL = 4'd3,
    ALU_DIV = 4'd4, ALU_AND = 4'd5, ALU_OR  = 4'd6, ALU_XOR = 4'd7
  } alu_op_e;

  typedef enum logic [OW-1:0] {
    MEM_NOP = 4'd0, MEM_LD = 4'd1, MEM_ST = 4'd2, MEM_LDI = 4'd3
  } mem_op_e;

  typedef enum logic [OW-1:0] {
    CTL_NOP = 4'd0, CTL_JMP = 4'd1, CTL_CALL = 4'd2, CTL_BZ = 4'd3, CTL_BPOS = 4'd4
  } ctl_op_e;
endpackage

// File: rtl/vliw_alu.sv
module vliw_alu
  import vliw_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [OW-1:0]   op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o,
  output logic            wen_o
);
  always_comb begin
    res_o = '0;
    wen_o = 1'b1;
    case (alu_op_e'(op_i))
      ALU_ADD: res_o = a_i + b_i;
      ALU_SUB: res_o = a_i - b_i;
      ALU_MUL: res_o = a_i * b_i;
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_XOR: res_o = a_i ^ b_i;
      default: wen_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/vliw_ctl.sv
module vliw_ctl
  import vliw_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            valid_i,
  input  logic [OW-1:0]   op_i,
  input  logic [XLEN-1:0] test_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [DW-1:0]   disp_i,
  output logic            take_o,
  output logic            link_we_o,
  output logic [XLEN-1:0] target_o
);
  logic is_zero, is_pos;

  assign is_zero  = (test_i == '0);
  assign is_pos   = !test_i[XLEN-1] && !is_zero;
  assign target_o = base_i + {{(XLEN-DW){disp_i[DW-1]}}, disp_i};

  always_comb begin
    take_o    = 1'b0;
    link_we_o = 1'b0;
    case (ctl_op_e'(op_i))
      CTL_JMP:  take_o = 1'b1;
      CTL_CALL: begin take_o = 1'b1; link_we_o = 1'b1; end
      CTL_BZ:   take_o = is_zero;
      CTL_BPOS: take_o = is_pos;
      default:  take_o = 1'b0;
    endcase
    take_o    = take_o & valid_i;
    link_we_o = link_we_o & valid_i;
  end
endmodule

// File: rtl/vliw_regfile.sv
module vliw_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 64,
  parameter int NRD  = 8,
  parameter int NWR  = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NRD-1:0][AW-1:0]    rd_addr_i,
  output logic [NRD-1:0][XLEN-1:0]  rd_data_o,
  input  logic [NWR-1:0]            wr_en_i,
  input  logic [NWR-1:0][AW-1:0]    wr_addr_i,
  input  logic [NWR-1:0][XLEN-1:0]  wr_data_i,
  output logic [NREG-1:0][XLEN-1:0] state_o
);
  logic [NREG-1:0][XLEN-1:0] regs_q, regs_d;
  logic                      upd_en;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data_o[p] = regs_q[rd_addr_i[p]];
  end

  // Later ports overwrite earlier ones: higher index has priority.
  always_comb begin
    regs_d = regs_q;
    for (int w = 0; w < NWR; w++) begin
      if (wr_en_i[w]) regs_d[wr_addr_i[w]] = wr_data_i[w];
    end
  end

  assign upd_en = |wr_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      regs_q <= '0;
    else if (upd_en) regs_q <= regs_d;
  end

  assign state_o = regs_q;
endmodule

// File: rtl/vliw_core.sv
module vliw_core
  import vliw_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [IW-1:0]   instr,
  output logic            mem_valid,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            br_take,
  output logic [XLEN-1:0] br_target,
  input  logic [XLEN-1:0] br_link
);
  localparam int NALU = 2;
  localparam int WP_CALL = NALU;
  localparam int WP_MEM  = NALU + 1;

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  word_t iw;
  assign iw = word_t'(instr);

  logic [NRD-1:0][RW-1:0]     rd_addr;
  logic [NRD-1:0][XLEN-1:0]   rd_data;
  logic [NWR-1:0]             wr_en;
  logic [NWR-1:0][RW-1:0]     wr_addr;
  logic [NWR-1:0][XLEN-1:0]   wr_data;
  logic [NREG-1:0][XLEN-1:0]  rf_state;

  // read ports: 0..3 arithmetic sources, 4 mem reg, 5 mem index, 6 ctl reg, 7 ctl index
  assign rd_addr = {iw.c.x, iw.c.r, iw.m.x, iw.m.r, iw.b.s2, iw.b.s1, iw.a.s2, iw.a.s1};

  alu_slot_t             alu_slots [NALU];
  logic [NALU-1:0][XLEN-1:0] alu_res;
  logic [NALU-1:0]       alu_wen;
  assign alu_slots[0] = iw.a;
  assign alu_slots[1] = iw.b;

  for (genvar g = 0; g < NALU; g++) begin : g_alu
    vliw_alu #(.XLEN(XLEN)) u_alu (
      .op_i (alu_slots[g].op),
      .a_i  (rd_data[2*g]),
      .b_i  (rd_data[2*g+1]),
      .res_o(alu_res[g]),
      .wen_o(alu_wen[g])
    );
    assign wr_en[g]   = instr_valid & alu_wen[g];
    assign wr_addr[g] = alu_slots[g].dst;
    assign wr_data[g] = alu_res[g];
  end

  // memory slot
  logic is_ld, is_st, is_ldi;
  assign is_ld  = (mem_op_e'(iw.m.op) == MEM_LD);
  assign is_st  = (mem_op_e'(iw.m.op) == MEM_ST);
  assign is_ldi = (mem_op_e'(iw.m.op) == MEM_LDI);

  assign mem_valid = instr_valid & (is_ld | is_st);
  assign mem_we    = instr_valid & is_st;
  assign mem_addr  = rd_data[5] + {{(XLEN-DW){iw.m.disp[DW-1]}}, iw.m.disp};
  assign mem_wdata = rd_data[4];

  assign wr_en[WP_MEM]   = instr_valid & (is_ld | is_ldi);
  assign wr_addr[WP_MEM] = iw.m.r;
  assign wr_data[WP_MEM] = is_ld ? mem_rdata : XLEN'({iw.m.x, iw.m.disp});

  // control slot
  logic link_we;
  vliw_ctl #(.XLEN(XLEN)) u_ctl (
    .valid_i  (instr_valid),
    .op_i     (iw.c.op),
    .test_i   (rd_data[6]),
    .base_i   (rd_data[7]),
    .disp_i   (iw.c.disp),
    .take_o   (br_take),
    .link_we_o(link_we),
    .target_o (br_target)
  );
  assign wr_en[WP_CALL]   = link_we;
  assign wr_addr[WP_CALL] = iw.c.r;
  assign wr_data[WP_CALL] = br_link;

  vliw_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(NRD), .NWR(NWR)) u_rf (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .state_o  (rf_state)
  );
endmodule

// File: rtl/vliw_core_chk.sv
module vliw_core_chk
  import vliw_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic                      clk,
  input logic                      rst_core_n,
  input logic                      instr_valid,
  input logic [IW-1:0]             instr,
  input logic                      mem_valid,
  input logic                      br_take,
  input logic [XLEN-1:0]           mem_rdata,
  input logic [XLEN-1:0]           br_link,
  input logic [NREG-1:0][XLEN-1:0] rf_state
);
  logic [OW-1:0] a_op, b_op, m_op, c_op;
  logic [RW-1:0] m_r, c_r;
  assign a_op = instr[87:84];
  assign b_op = instr[65:62];
  assign m_op = instr[55:52];
  assign m_r  = instr[51:46];
  assign c_op = instr[27:24];
  assign c_r  = instr[23:18];

  assert_idle_no_req_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    !instr_valid |-> (!mem_valid && !br_take));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    !instr_valid |=> $stable(rf_state));

  assert_nop_hold_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (instr_valid && a_op == 4'd0 && b_op == 4'd0 && m_op == 4'd0 && c_op == 4'd0)
    |=> $stable(rf_state));

  assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (instr_valid && m_op == 4'd1) |=> rf_state[$past(m_r)] == $past(mem_rdata));

  assert_call_link_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (instr_valid && c_op == 4'd2 && !((m_op == 4'd1 || m_op == 4'd3) && m_r == c_r))
    |=> rf_state[$past(c_r)] == $past(br_link));
endmodule

bind vliw_core vliw_core_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .instr_valid(instr_valid),
  .instr      (instr),
  .mem_valid  (mem_valid),
  .br_take    (br_take),
  .mem_rdata  (mem_rdata),
  .br_link    (br_link),
  .rf_state   (rf_state)
);

// File: tb/sim_vliw_core.sv
module sim_vliw_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [99:0] instr = '0;
  logic        mem_valid, mem_we, br_take;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, br_target;
  logic [31:0] br_link = '0;
  logic [31:0] bmem [256];

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic        c_mv, c_we, c_take;
  logic [31:0] c_addr, c_wd, c_tgt;

  always #5 clk = ~clk;

  assign mem_rdata = bmem[mem_addr[7:0]];

  vliw_core u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .br_take(br_take),
    .br_target(br_target), .br_link(br_link)
  );

  function automatic logic [99:0] enc(
      input logic [5:0] as1, as2, input logic [3:0] aop, input logic [5:0] ad,
      input logic [5:0] bs1, bs2, input logic [3:0] bop, input logic [5:0] bd,
      input logic [3:0] mop, input logic [5:0] mr, mx, input logic [11:0] md,
      input logic [3:0] cop, input logic [5:0] cr, cx, input logic [11:0] cd);
    return {as1, as2, aop, ad, bs1, bs2, bop, bd, mop, mr, mx, md, cop, cr, cx, cd};
  endfunction

  function automatic logic [99:0] w_ldi(input logic [5:0] r, input logic [17:0] v);
    return enc(0,0,0,0, 0,0,0,0, 4'd3, r, v[17:12], v[11:0], 0,0,0,0);
  endfunction

  function automatic logic [99:0] w_ld(input logic [5:0] r, x, input logic [11:0] d);
    return enc(0,0,0,0, 0,0,0,0, 4'd1, r, x, d, 0,0,0,0);
  endfunction

  function automatic logic [99:0] w_st(input logic [5:0] r);
    return enc(0,0,0,0, 0,0,0,0, 4'd2, r, 6'd0, 12'd0, 0,0,0,0);
  endfunction

  function automatic logic [17:0] pat(input int r);
    return 18'((r * 2731 + 17) & 32'h3ffff);
  endfunction

  function automatic logic [32:0] alu_ref(input int op, input logic [31:0] a, b);
    case (op)
      1: return {1'b1, a + b};
      2: return {1'b1, a - b};
      3: return {1'b1, a * b};
      5: return {1'b1, a & b};
      6: return {1'b1, a | b};
      7: return {1'b1, a ^ b};
      default: return {1'b0, 32'h0};
    endcase
  endfunction

  task automatic step(input logic [99:0] w, input logic v = 1'b1);
    @(negedge clk);
    instr = w;
    instr_valid = v;
    #1;
    c_mv = mem_valid; c_we = mem_we; c_addr = mem_addr;
    c_wd = mem_wdata; c_take = br_take; c_tgt = br_target;
    @(posedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rdchk(input logic [5:0] r, input logic [31:0] exp, input string tag);
    step(w_st(r));
    chk(tag, c_wd, exp);
  endtask

  logic [31:0] pa [8];
  logic [31:0] pb [8];

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    pa = '{32'h0, 32'h1, 32'hffffffff, 32'h80000000, 32'h7fffffff, 32'h12345678, 32'hdeadbeef, 32'h5};
    pb = '{32'h3, 32'hffffffff, 32'h1, 32'h80000000, 32'h0f0f0f0f, 32'h9abcdef0, 32'h0000ffff, 32'hfffffffb};
    for (int i = 0; i < 256; i++) bmem[i] = 32'h0;
    for (int i = 0; i < 8; i++) begin
      bmem[16+i] = pa[i];
      bmem[32+i] = pb[i];
    end
    bmem[40] = 32'hfffffff0;
    bmem[41] = 32'hA5A5_0001;

    repeat (3) @(posedge clk);
    #1;
    chk("R1 mem_valid in reset", {31'b0, mem_valid}, 32'h0);
    chk("R1 br_take in reset", {31'b0, br_take}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: all registers zero after reset
    for (int r = 0; r < 64; r++) rdchk(6'(r), 32'h0, $sformatf("R1 reg %0d", r));

    // R5 load immediate sweep, field positions per R2
    for (int r = 0; r < 64; r++) step(w_ldi(6'(r), pat(r)));
    for (int r = 0; r < 64; r++) rdchk(6'(r), {14'h0, pat(r)}, $sformatf("R5 R2 ldi reg %0d", r));
    step(w_ldi(6'd0, 18'h0));

    // R3/R4 arithmetic sweep, both slots, all 16 codes
    for (int p = 0; p < 8; p++) begin
      step(w_ld(6'd1, 6'd0, 12'(16 + p)));
      step(w_ld(6'd2, 6'd0, 12'(32 + p)));
      for (int op = 0; op < 16; op++) begin
        logic [32:0] ea, eb;
        step(w_ldi(6'd3, 18'h2aaaa));
        step(w_ldi(6'd4, 18'h15555));
        step(enc(6'd1, 6'd2, 4'(op), 6'd3, 6'd2, 6'd1, 4'(op), 6'd4,
                 0,0,0,0, 0,0,0,0));
        ea = alu_ref(op, pa[p], pb[p]);
        eb = alu_ref(op, pb[p], pa[p]);
        rdchk(6'd3, ea[32] ? ea[31:0] : 32'h2aaaa, $sformatf("R3 R4 slotA op %0d pair %0d", op, p));
        rdchk(6'd4, eb[32] ? eb[31:0] : 32'h15555, $sformatf("R3 R4 slotB op %0d pair %0d", op, p));
      end
    end

    // R7: reads see pre-word values. r1=A, r2=B, r5=C
    step(w_ld(6'd1, 6'd0, 12'd21));
    step(w_ld(6'd2, 6'd0, 12'd37));
    step(w_ldi(6'd5, 18'h0c0de));
    step(enc(6'd1, 6'd2, 4'd1, 6'd5, 6'd5, 6'd0, 4'd1, 6'd6,
             4'd2, 6'd5, 6'd0, 12'd0, 0,0,0,0));
    chk("R7 store sees old value", c_wd, 32'h0c0de);
    rdchk(6'd6, 32'h0c0de, "R7 slotB sees old value");
    rdchk(6'd5, pa[5] + pb[5], "R7 slotA result committed");
    step(enc(6'd2, 6'd0, 4'd6, 6'd1, 6'd1, 6'd0, 4'd6, 6'd2, 0,0,0,0, 0,0,0,0));
    rdchk(6'd1, pb[5], "R7 swap r1");
    rdchk(6'd2, pa[5], "R7 swap r2");

    // R8 priority on r10: r1=B, r2=A now
    br_link = 32'h1111_2222;
    step(enc(6'd1, 6'd0, 4'd1, 6'd10, 6'd2, 6'd0, 4'd1, 6'd10,
             4'd1, 6'd10, 6'd0, 12'd41, 4'd2, 6'd10, 6'd0, 12'd0));
    rdchk(6'd10, 32'hA5A5_0001, "R8 load beats all");
    step(enc(6'd1, 6'd0, 4'd1, 6'd10, 6'd2, 6'd0, 4'd1, 6'd10,
             4'd3, 6'd10, 6'h3, 12'h456, 4'd2, 6'd10, 6'd0, 12'd0));
    rdchk(6'd10, 32'h3456, "R8 load immediate beats call");
    step(enc(6'd1, 6'd0, 4'd1, 6'd10, 6'd2, 6'd0, 4'd1, 6'd10,
             0,0,0,0, 4'd2, 6'd10, 6'd0, 12'd0));
    rdchk(6'd10, 32'h1111_2222, "R8 call beats arithmetic");
    step(enc(6'd1, 6'd0, 4'd1, 6'd10, 6'd2, 6'd0, 4'd1, 6'd10,
             0,0,0,0, 0,0,0,0));
    rdchk(6'd10, pa[5], "R8 slotB beats slotA");

    // R6 control sweep
    step(w_ldi(6'd20, 18'h0));
    step(w_ldi(6'd21, 18'h5));
    step(w_ld(6'd22, 6'd0, 12'd40));
    step(w_ldi(6'd23, 18'h1));
    for (int t = 20; t < 24; t++) begin
      logic [31:0] tv;
      tv = (t == 20) ? 32'h0 : (t == 21) ? 32'h5 : (t == 22) ? 32'hfffffff0 : 32'h1;
      br_link = tv;
      for (int op = 0; op < 16; op++) begin
        logic et;
        et = (op == 1 || op == 2) ? 1'b1 :
             (op == 3) ? (tv == 0) :
             (op == 4) ? (!tv[31] && tv != 0) : 1'b0;
        step(enc(0,0,0,0, 0,0,0,0, 0,0,0,0, 4'(op), 6'(t), 6'd21, 12'hffe));
        chk($sformatf("R6 R4 take op %0d reg %0d", op, t), {31'b0, c_take}, {31'b0, et});
      end
      chk("R6 target negative disp", c_tgt, 32'd3);
    end
    step(enc(0,0,0,0, 0,0,0,0, 0,0,0,0, 4'd1, 6'd0, 6'd21, 12'h7ff));
    chk("R6 target positive disp", c_tgt, 32'd2052);
    rdchk(6'd22, 32'hfffffff0, "R6 non-call keeps reg");
    br_link = 32'hcafe_f00d;
    step(enc(0,0,0,0, 0,0,0,0, 0,0,0,0, 4'd2, 6'd24, 6'd0, 12'd0));
    rdchk(6'd24, 32'hcafe_f00d, "R6 call writes link");

    // R5 memory request fields
    step(w_ld(6'd25, 6'd21, 12'hffd));
    chk("R5 load valid", {31'b0, c_mv}, 32'h1);
    chk("R5 load we", {31'b0, c_we}, 32'h0);
    chk("R5 load addr", c_addr, 32'd2);
    step(enc(0,0,0,0, 0,0,0,0, 4'd2, 6'd24, 6'd21, 12'h7ff, 0,0,0,0));
    chk("R5 store we", {31'b0, c_we}, 32'h1);
    chk("R5 store addr", c_addr, 32'd2052);
    chk("R5 store data", c_wd, 32'hcafe_f00d);
    step(w_ldi(6'd26, 18'h3ffff));
    chk("R5 ldi no request", {31'b0, c_mv}, 32'h0);
    rdchk(6'd26, 32'h0003ffff, "R5 ldi zero extend");

    // R4 unused memory codes
    for (int op = 4; op < 16; op++) begin
      step(enc(0,0,0,0, 0,0,0,0, 4'(op), 6'd26, 6'd0, 12'd41, 0,0,0,0));
      chk($sformatf("R4 mem op %0d no request", op), {31'b0, c_mv}, 32'h0);
    end
    rdchk(6'd26, 32'h0003ffff, "R4 mem nop codes keep reg");

    // R9 idle word
    br_link = 32'h0;
    step(enc(6'd1, 6'd2, 4'd1, 6'd26, 6'd1, 6'd2, 4'd2, 6'd26,
             4'd2, 6'd26, 6'd0, 12'd0, 4'd2, 6'd26, 6'd0, 12'd0), 1'b0);
    chk("R9 idle no mem", {31'b0, c_mv}, 32'h0);
    chk("R9 idle no take", {31'b0, c_take}, 32'h0);
    rdchk(6'd26, 32'h0003ffff, "R9 idle keeps reg");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule